// File: doc/BRIEF.md
# Four-Way Set-Associative Cache Controller

This block is the control and storage for a small 256-byte cache placed between a processor request port and a 4 KB main memory made of four 1 KB banks. The cache has four sets of four ways, and each line holds 16 bytes. Every request carries a 12-bit byte address. The controller compares the tag against all four ways of the addressed set in one step. A read hit is served from the line storage. A read miss fetches the whole line from memory and places it in a way chosen by a three-bit binary-tree pseudo-LRU kept for each set.

Writes go to memory every time (write-through). A write that hits also updates the byte in the cached line. A write that misses leaves the cache unchanged (no write-allocate). The processor side uses a simple request/done handshake and handles one access at a time. The memory side uses a request/acknowledge handshake. A read transfer carries a full 128-bit line and a write transfer carries a single byte.

Top module: `sa4_cache_ctrl`

## Requirements
- R1: After synchronous reset, `done` and `mem_req` are low and every line is invalid, so the first read of any address is a miss.
- R2: The address is split into a byte offset in bits [3:0], a set index in bits [5:4] and a tag in bits [11:6]. Lines with the same tag in different sets do not evict one another.
- R3: A read hit returns the addressed byte on `rdata`, makes no memory request, and raises `done` on the 3rd rising edge after the edge that accepts `req`.
- R4: A read miss issues `mem_req` with `mem_we` low, `mem_bank` = addr[11:10] and `mem_addr` = {addr[9:4], 4'b0}. Line byte k is taken from `mem_rdata[8k+7:8k]`. The requested byte is returned. If `mem_ack` comes one cycle after `mem_req` rises, `done` rises on the 5th edge after acceptance.
- R5: On a miss, the lowest-numbered invalid way of the set is filled before pseudo-LRU replacement is used, so four different tags in one set are all resident afterwards.
- R6: Each set has three tree bits. Bit 0 = 0 selects the victim from ways {0,1} and bit 0 = 1 selects it from {2,3}. Bit 1 picks way 0 (0) or way 1 (1), and bit 2 picks way 2 (0) or way 3 (1). Every hit and every fill sets the bits on the path to point away from the way just used. All bits clear on reset.
- R7: A write hit writes the byte to memory (`mem_we` high, `mem_bank`/`mem_addr` = byte address) and to the cached line, and raises `done` on the 3rd edge after acceptance when `mem_ack` follows one cycle after `mem_req`.
- R8: A write miss writes memory only. It does not fill a line, so a later read of that address misses.
- R9: `done` is a pulse one cycle wide. `req` is ignored while an access is in progress.
- R10: `mem_req` stays high until `mem_ack` is seen and drops on the next edge. Memory wait states lengthen the access by the same number of cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Processor access request, sampled when idle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte address |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid with `done` |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = byte write, 0 = line read |
| mem_bank | output | 2 | Memory bank select |
| mem_addr | output | 10 | Byte address inside the bank (line aligned for reads) |
| mem_wdata | output | 8 | Byte written to memory |
| mem_rdata | input | 128 | Line returned by memory |
| mem_ack | input | 1 | Memory transfer complete |

## Verification
The read sequence fills one set with four tags, then mixes hits and misses in an order where each eviction is decided by the current tree bits. A wrong victim therefore shows up as an unexpected miss on a later access. Reads to a second set that share tag bits with lines in the first set separate set indexing from tag comparison. A write hit followed by a read with no memory traffic shows that the line was updated. A write miss followed by a read miss shows that no line was allocated. Finally, a held request, a slow memory and a reset in the middle of operation exercise the busy-ignore rule, the request hold and the invalidation.

// File: rtl/sa4_cache_pkg.sv
package sa4_cache_pkg;
  localparam int ADDR_W     = 12;
  localparam int LINE_BYTES = 16;
  localparam int SETS       = 4;
  localparam int WAYS       = 4;
  localparam int BANKS      = 4;
  localparam int BYTE_W     = 8;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOK,
    S_READ,
    S_RESP,
    S_FILL,
    S_WRITE
  } ctrl_state_t;
endpackage

// File: rtl/sa4_tag_store.sv
module sa4_tag_store #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int TAG_W = 6,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  output logic             has_free,
  output logic [WAY_W-1:0] free_way,
  input  logic             fill_en,
  input  logic [SET_W-1:0] fill_set,
  input  logic [WAY_W-1:0] fill_way,
  input  logic [TAG_W-1:0] fill_tag
);
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAYS-1:0]  hit_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
  end

  always_comb begin
    hit      = |hit_vec;
    hit_way  = '0;
    has_free = ~&vld_q[lk_set];
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w])         hit_way  = WAY_W'(w);
      if (!vld_q[lk_set][w])  free_way = WAY_W'(w);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (fill_en) begin
      vld_q[fill_set][fill_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_set][fill_way] <= fill_tag;
  end

  // R5
  hit_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
endmodule

// File: rtl/sa4_plru.sv
module sa4_plru #(
  parameter int SETS = 4,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int NODES = WAYS - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] rd_set,
  output logic [WAY_W-1:0] victim,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way
);
  logic [NODES-1:0] tree_q [SETS];
  logic [NODES-1:0] cur;
  logic [NODES-1:0] nxt;

  always_comb begin
    cur    = tree_q[rd_set];
    victim = cur[0] ? {1'b1, cur[2]} : {1'b0, cur[1]};
  end

  always_comb begin
    nxt = tree_q[touch_set];
    if (!touch_way[1]) begin
      nxt[0] = 1'b1;
      nxt[1] = ~touch_way[0];
    end else begin
      nxt[0] = 1'b0;
      nxt[2] = ~touch_way[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (touch_en) begin
      tree_q[touch_set] <= nxt;
    end
  end

  // R6
  victim_moves_chk: assert property (@(posedge clk) disable iff (rst)
    touch_en |=> (rd_set != $past(touch_set)) || (victim != $past(touch_way)));
endmodule

// File: rtl/sa4_line_store.sv
module sa4_line_store #(
  parameter int DEPTH      = 16,
  parameter int LINE_BYTES = 16,
  parameter int BYTE_W     = 8,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int LINE_W = LINE_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_full,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [OFF_W-1:0]  wr_lane,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_line
);
  for (genvar g = 0; g < LINE_BYTES; g++) begin : g_lane
    localparam logic [OFF_W-1:0] LANE = OFF_W'(g);
    logic [BYTE_W-1:0] ram [DEPTH];
    logic [BYTE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (wr_en && (wr_full || wr_lane == LANE))
        ram[wr_idx] <= wr_line[g*BYTE_W +: BYTE_W];
      rd_q <= ram[rd_idx];
    end

    assign rd_line[g*BYTE_W +: BYTE_W] = rd_q;
  end
endmodule

// File: rtl/sa4_cache_ctrl.sv
module sa4_cache_ctrl
  import sa4_cache_pkg::*;
#(
  parameter int ADDR_W     = sa4_cache_pkg::ADDR_W,
  parameter int LINE_BYTES = sa4_cache_pkg::LINE_BYTES,
  parameter int SETS       = sa4_cache_pkg::SETS,
  parameter int WAYS       = sa4_cache_pkg::WAYS,
  parameter int BANKS      = sa4_cache_pkg::BANKS,
  parameter int BYTE_W     = sa4_cache_pkg::BYTE_W,
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int SET_W   = $clog2(SETS),
  localparam int WAY_W   = $clog2(WAYS),
  localparam int TAG_W   = ADDR_W - OFF_W - SET_W,
  localparam int BANK_W  = $clog2(BANKS),
  localparam int BANK_AW = ADDR_W - BANK_W,
  localparam int LINE_W  = LINE_BYTES * BYTE_W,
  localparam int DEPTH   = SETS * WAYS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req,
  input  logic               we,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BYTE_W-1:0]  wdata,
  output logic [BYTE_W-1:0]  rdata,
  output logic               done,
  output logic               mem_req,
  output logic               mem_we,
  output logic [BANK_W-1:0]  mem_bank,
  output logic [BANK_AW-1:0] mem_addr,
  output logic [BYTE_W-1:0]  mem_wdata,
  input  logic [LINE_W-1:0]  mem_rdata,
  input  logic               mem_ack
);
  ctrl_state_t       state;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [BYTE_W-1:0] wdata_q;
  logic [WAY_W-1:0]  way_q;
  logic              hit_q;

  logic [OFF_W-1:0]  off_q;
  logic [SET_W-1:0]  set_q;
  logic [TAG_W-1:0]  tag_q;

  assign off_q = addr_q[OFF_W-1:0];
  assign set_q = addr_q[OFF_W +: SET_W];
  assign tag_q = addr_q[ADDR_W-1 -: TAG_W];

  logic             hit;
  logic [WAY_W-1:0] hit_way;
  logic             has_free;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] plru_victim;
  logic             fill_done;
  logic             wr_hit_done;
  logic             touch_en;
  logic [WAY_W-1:0] touch_way;
  logic [LINE_W-1:0] rd_line;
  logic [LINE_W-1:0] wr_line;
  logic [SET_W+WAY_W-1:0] line_idx;

  assign fill_done   = (state == S_FILL) && mem_ack;
  assign wr_hit_done = (state == S_WRITE) && mem_ack && hit_q;
  assign touch_en    = ((state == S_LOOK) && hit) || fill_done;
  assign touch_way   = (state == S_LOOK) ? hit_way : way_q;
  assign line_idx    = {set_q, way_q};
  assign wr_line     = (state == S_FILL) ? mem_rdata : {LINE_BYTES{wdata_q}};

  sa4_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .lk_set   (set_q),
    .lk_tag   (tag_q),
    .hit      (hit),
    .hit_way  (hit_way),
    .has_free (has_free),
    .free_way (free_way),
    .fill_en  (fill_done),
    .fill_set (set_q),
    .fill_way (way_q),
    .fill_tag (tag_q)
  );

  sa4_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
    .clk       (clk),
    .rst       (rst),
    .rd_set    (set_q),
    .victim    (plru_victim),
    .touch_en  (touch_en),
    .touch_set (set_q),
    .touch_way (touch_way)
  );

  sa4_line_store #(.DEPTH(DEPTH), .LINE_BYTES(LINE_BYTES), .BYTE_W(BYTE_W)) u_lines (
    .clk     (clk),
    .wr_en   (fill_done || wr_hit_done),
    .wr_full (state == S_FILL),
    .wr_idx  (line_idx),
    .wr_lane (off_q),
    .wr_line (wr_line),
    .rd_idx  (line_idx),
    .rd_line (rd_line)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      addr_q    <= '0;
      we_q      <= 1'b0;
      wdata_q   <= '0;
      way_q     <= '0;
      hit_q     <= 1'b0;
      rdata     <= '0;
      done      <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_bank  <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req) begin
            addr_q  <= addr;
            we_q    <= we;
            wdata_q <= wdata;
            state   <= S_LOOK;
          end
        end
        S_LOOK: begin
          hit_q    <= hit;
          mem_bank <= addr_q[ADDR_W-1 -: BANK_W];
          if (we_q) begin
            way_q     <= hit_way;
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= addr_q[BANK_AW-1:0];
            mem_wdata <= wdata_q;
            state     <= S_WRITE;
          end else if (hit) begin
            way_q <= hit_way;
            state <= S_READ;
          end else begin
            way_q    <= has_free ? free_way : plru_victim;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= {addr_q[BANK_AW-1:OFF_W], {OFF_W{1'b0}}};
            state    <= S_FILL;
          end
        end
        S_FILL: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            state   <= S_READ;
          end
        end
        S_READ: state <= S_RESP;
        S_RESP: begin
          rdata <= rd_line[{off_q, 3'b000} +: BYTE_W];
          done  <= 1'b1;
          state <= S_IDLE;
        end
        S_WRITE: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            done    <= 1'b1;
            state   <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  memreq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> mem_req);

  // R10
  memreq_release_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> !mem_req);
endmodule

// File: tb/sa4_cache_ctrl_bench.sv
`timescale 1ns/1ps
module sa4_cache_ctrl_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req = 1'b0;
  logic         we = 1'b0;
  logic [11:0]  addr = '0;
  logic [7:0]   wdata = '0;
  logic [7:0]   rdata;
  logic         done;
  logic         mem_req;
  logic         mem_we;
  logic [1:0]   mem_bank;
  logic [9:0]   mem_addr;
  logic [7:0]   mem_wdata;
  logic [127:0] mem_rdata;
  logic         mem_ack;

  int checks = 0;
  int fails  = 0;
  int mem_wait = 0;
  int wcnt;
  bit finished = 0;

  logic [7:0] bmem   [4096];
  logic [7:0] shadow [4096];

  always #4 clk = ~clk;

  sa4_cache_ctrl u_sa4_cache_ctrl (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .done(done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_bank(mem_bank), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 29) ^ (a >> 4) ^ 8'h5C);
  endfunction

  // banked memory model: ack after mem_wait extra cycles
  always @(posedge clk) begin
    if (rst) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      wcnt      <= 0;
      for (int a = 0; a < 4096; a++) bmem[a] <= pat(a);
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        if (wcnt >= mem_wait) begin
          wcnt    <= 0;
          mem_ack <= 1'b1;
          if (mem_we) bmem[{mem_bank, mem_addr}] <= mem_wdata;
          else
            for (int k = 0; k < 16; k++)
              mem_rdata[k*8 +: 8] <= bmem[{mem_bank, mem_addr[9:4], 4'(k)}];
        end else begin
          wcnt <= wcnt + 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic shadow_init();
    for (int a = 0; a < 4096; a++) shadow[a] = pat(a);
  endtask

  // one access; lat = edges after the accepting edge until done seen
  task automatic access(input logic w, input logic [11:0] a, input logic [7:0] d,
                        output int lat, output logic [7:0] rd,
                        output bit saw_rd, output bit saw_wr, output bit fields_ok);
    lat = 0; saw_rd = 0; saw_wr = 0; fields_ok = 1;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (mem_req && !mem_we) begin
        saw_rd = 1;
        if (mem_bank != a[11:10] || mem_addr != {a[9:4], 4'h0}) fields_ok = 0;
      end
      if (mem_req && mem_we) begin
        saw_wr = 1;
        if (mem_bank != a[11:10] || mem_addr != a[9:0] || mem_wdata != d) fields_ok = 0;
      end
      if (done) break;
    end
    rd = rdata;
  endtask

  // {we, addr, wdata, expect_miss}
  localparam int NV = 21;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 12'h003, 8'h00, 1'b1},  // A -> way0 (R1 R4 R5)
    {1'b0, 12'h00A, 8'h00, 1'b0},  // A hit (R3)
    {1'b0, 12'h045, 8'h00, 1'b1},  // B -> way1
    {1'b0, 12'h08F, 8'h00, 1'b1},  // C -> way2
    {1'b0, 12'h0C1, 8'h00, 1'b1},  // D -> way3
    {1'b0, 12'h010, 8'h00, 1'b1},  // set1 tag0 (R2)
    {1'b0, 12'h014, 8'h00, 1'b0},  // set1 hit (R2)
    {1'b0, 12'h047, 8'h00, 1'b0},  // B hit
    {1'b0, 12'h001, 8'h00, 1'b0},  // A hit -> victim way2
    {1'b0, 12'hC05, 8'h00, 1'b1},  // E evicts C (R6)
    {1'b0, 12'h080, 8'h00, 1'b1},  // C evicts B (R6)
    {1'b0, 12'h00F, 8'h00, 1'b0},  // A hit
    {1'b0, 12'hC00, 8'h00, 1'b0},  // E hit
    {1'b0, 12'h0C2, 8'h00, 1'b0},  // D hit
    {1'b0, 12'h040, 8'h00, 1'b1},  // B evicts C (R6)
    {1'b0, 12'h081, 8'h00, 1'b1},  // C evicts E (R6)
    {1'b0, 12'h000, 8'h00, 1'b0},  // A hit
    {1'b1, 12'h0C4, 8'h5A, 1'b0},  // write hit on D (R7)
    {1'b0, 12'h0C4, 8'h00, 1'b0},  // read back, no memory (R7)
    {1'b1, 12'h2D3, 8'hA5, 1'b1},  // write miss set1 (R8)
    {1'b0, 12'h2D3, 8'h00, 1'b1}   // still a miss (R8)
  };

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int lat;
    logic [7:0] rd;
    bit srd, swr, fok;
    int dones;
    int reqcnt;

    shadow_init();
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(done == 1'b0, "R1 done after reset", done, 0);
    check(mem_req == 1'b0, "R1 mem_req after reset", mem_req, 0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      logic        vw;
      logic [11:0] va;
      logic [7:0]  vd;
      logic        vm;
      {vw, va, vd, vm} = VEC[v];
      access(vw, va, vd, lat, rd, srd, swr, fok);
      check(fok, "R4/R7 memory request fields", fok, 1);
      if (vw) begin
        shadow[va] = vd;
        check(lat == 3, "R7 write latency", lat, 3);
        check(swr && !srd, "R8 write goes to memory only, no fill", {swr, srd}, 2);
        check(bmem[va] == vd, "R7 memory byte written", bmem[va], vd);
      end else begin
        check(srd == vm, vm ? "R4 expected miss (R5/R6 victim)" : "R3 expected hit", srd, vm);
        check(lat == (vm ? 5 : 3), vm ? "R4 miss latency" : "R3 hit latency", lat, vm ? 5 : 3);
        check(rd == shadow[va], "R2/R3/R4 read data", rd, shadow[va]);
      end
    end

    // R9: req held high while busy is ignored; done is one cycle
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 12'h0C4;
    @(posedge clk);
    @(negedge clk);
    addr = 12'h111;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    dones = 0;
    rd = 8'h00;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (done) begin
        dones++;
        rd = rdata;
      end
    end
    check(dones == 1, "R9 single done pulse while req held", dones, 1);
    check(rd == shadow[12'h0C4], "R9 result belongs to first request", rd, shadow[12'h0C4]);

    // R10: memory with three wait states
    mem_wait = 3;
    reqcnt = 0;
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 12'h300;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    lat = 0;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (mem_req) reqcnt++;
      if (done) break;
    end
    check(lat == 8, "R10 miss latency with wait states", lat, 8);
    check(reqcnt == 5, "R10 mem_req held until ack", reqcnt, 5);
    check(rdata == shadow[12'h300], "R10 read data", rdata, shadow[12'h300]);
    mem_wait = 0;

    // R1: reset invalidates lines
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    shadow_init();
    check(done == 1'b0 && mem_req == 1'b0, "R1 outputs after second reset", {done, mem_req}, 0);
    access(1'b0, 12'h000, 8'h00, lat, rd, srd, swr, fok);
    check(srd == 1'b1, "R1 cached line invalid after reset", srd, 1);
    check(lat == 5, "R1 miss latency after reset", lat, 5);
    check(rd == shadow[12'h000], "R1 read data after reset", rd, shadow[12'h000]);

    finish_run();
  end
endmodule